// File: doc/BRIEF.md
# Programmable Almost-Full Flag Synchronizer

This block drives the active-low almost-full flag of a dual-clock FIFO. It runs entirely in the write clock domain. Its inputs are the write pointer, which the write logic keeps as a binary counter with one wrap bit, and the read pointer, which the read domain sends across as a Gray code. The block compares the number of stored words against a threshold equal to the FIFO depth minus a programmable offset.

The read pointer passes through a two-stage synchronizer before it reaches the comparator. A write can therefore pull the flag low in the same cycle as the write pointer advances. A read can only release the flag once its pointer has crossed into the write domain, which takes two write clock edges. The offset sits in a register that takes a preset value on reset and can be reloaded at any write clock edge through a load strobe. A word that the read side has moved into its output register counts as already read: the read pointer must already include it.

Top module: `afull_sync_flag`

## Requirements
- R1: While `rst_ni` is low and both pointers are zero, `afull_n_o` is 1. After reset the offset holds the `PRESET` parameter, so the flag is low exactly when the fill is at or above `DEPTH - PRESET`.
- R2: Once the pointers are settled, `afull_n_o` is 0 whenever the fill (`wr_ptr_i` minus the binary read pointer, modulo 2·DEPTH) is greater than or equal to `DEPTH - Y`, where Y is the current offset.
- R3: Once the pointers are settled, `afull_n_o` is 1 whenever the fill is less than or equal to `DEPTH - (Y+1)`.
- R4: A write that brings the fill to `DEPTH - Y` drives `afull_n_o` low in the same cycle that `wr_ptr_i` changes, with no clock edge in between. The flag never falls unless the write pointer or the offset changes.
- R5: After a read brings the fill down to `DEPTH - (Y+1)`, `afull_n_o` is still 0 after the first rising write clock edge and becomes 1 after the second. The flag never rises unless the synchronized read pointer or the offset changes.
- R6: When `off_load_i` is 1 at a rising `wclk_i` edge, Y takes `off_data_i` and the new threshold applies right after that edge. With `off_load_i` at 0, Y keeps its value.
- R7: `rd_ptr_gray_i` is a Gray code (binary b encoded as b ^ (b >> 1)). Both pointers are ADDR_W+1 bits wide, and the fill stays correct as the pointers wrap around 2·DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_ptr_i | input | ADDR_W+1 | Binary write pointer with wrap bit |
| rd_ptr_gray_i | input | ADDR_W+1 | Gray-coded read pointer from the read domain |
| off_load_i | input | 1 | Load strobe for the offset register |
| off_data_i | input | ADDR_W | New offset value Y |
| afull_n_o | output | 1 | Almost-full flag, active low |

## Verification
The assertions assume that the synchronized read pointer moves by at most one Gray step per write clock and only ever forward. They also assume that the write side never lets the fill it sees exceed DEPTH, and that the flag changes only through pointer or offset movement. The stimulus respects all of this. It advances each pointer by one word per write clock cycle and writes only up to a full FIFO. It changes the offset only when the FIFO is empty or while holding both pointers still. It jumps the pointers back to zero only while reset is asserted.

// File: rtl/afull_pkg.sv
`timescale 1ns/1ps
package afull_pkg;
  localparam int unsigned PTR_MAX_W = 32;

  function automatic logic [PTR_MAX_W-1:0] gray_to_bin(input logic [PTR_MAX_W-1:0] g);
    logic [PTR_MAX_W-1:0] b;
    b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
    for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/afull_gray_sync.sv
`timescale 1ns/1ps
module afull_gray_sync
  import afull_pkg::*;
#(
  parameter int unsigned W      = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= gray_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  logic [PTR_MAX_W-1:0] bin_wide;
  assign bin_wide = gray_to_bin(PTR_MAX_W'(stage_q[STAGES-1]));
  assign bin_o    = bin_wide[W-1:0];

  // input assumption: the read side moves one Gray step per write clock at most
  p_gray_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(stage_q[STAGES-1] ^ $past(stage_q[STAGES-1])) <= 1);
endmodule

// File: rtl/afull_offset_reg.sv
`timescale 1ns/1ps
module afull_offset_reg #(
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned PRESET = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [OFF_W-1:0] data_i,
  output logic [OFF_W-1:0] off_o
);
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= OFF_W'(PRESET);
    else if (load_i) off_q <= data_i;
  end

  assign off_o = off_q;

  p_off_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(off_o));
endmodule

// File: rtl/afull_level_cmp.sv
`timescale 1ns/1ps
module afull_level_cmp #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CNT_W = 9,
  parameter int unsigned OFF_W = 8
) (
  input  logic [CNT_W-1:0] wr_ptr_i,
  input  logic [CNT_W-1:0] rd_ptr_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [CNT_W-1:0] level_o,
  output logic             afull_n_o
);
  logic [CNT_W-1:0] thresh;

  // modulo subtraction handles the wrap bit
  assign level_o   = wr_ptr_i - rd_ptr_i;
  assign thresh    = CNT_W'(DEPTH) - CNT_W'(off_i);
  assign afull_n_o = (level_o < thresh);
endmodule

// File: rtl/afull_sync_flag.sv
`timescale 1ns/1ps
module afull_sync_flag #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned PRESET = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W  = ADDR_W + 1,
  localparam int unsigned OFF_W  = ADDR_W
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  wr_ptr_i,
  input  logic [CNT_W-1:0]  rd_ptr_gray_i,
  input  logic              off_load_i,
  input  logic [OFF_W-1:0]  off_data_i,
  output logic              afull_n_o
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [CNT_W-1:0] rd_bin;
  logic [CNT_W-1:0] level;
  logic [OFF_W-1:0] off_q;

  afull_gray_sync #(
    .W      (CNT_W),
    .STAGES (SYNC_STAGES)
  ) u_rd_sync (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .gray_i (rd_ptr_gray_i),
    .bin_o  (rd_bin)
  );

  afull_offset_reg #(
    .OFF_W  (OFF_W),
    .PRESET (PRESET)
  ) u_offset (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .load_i (off_load_i),
    .data_i (off_data_i),
    .off_o  (off_q)
  );

  afull_level_cmp #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .OFF_W (OFF_W)
  ) u_cmp (
    .wr_ptr_i  (wr_ptr_i),
    .rd_ptr_i  (rd_bin),
    .off_i     (off_q),
    .level_o   (level),
    .afull_n_o (afull_n_o)
  );

  p_level_range_r2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    level <= CNT_W'(DEPTH));

  p_fall_on_write_r4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ($fell(afull_n_o) && $stable(off_q)) |-> !$stable(wr_ptr_i));

  p_rise_after_sync_r5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ($rose(afull_n_o) && $stable(off_q)) |-> !$stable(rd_bin));
endmodule

// File: tb/afull_sync_flag_tb.sv
`timescale 1ns/1ps
module afull_sync_flag_tb_top;
  localparam int DEPTH  = 16;
  localparam int PRESET = 3;
  localparam int CNT_W  = 5;
  localparam int OFF_W  = 4;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic [CNT_W-1:0] wr_ptr;
  logic [CNT_W-1:0] rd_gray;
  logic             off_load;
  logic [OFF_W-1:0] off_data;
  logic             afull_n;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [CNT_W-1:0] wr;
  logic [CNT_W-1:0] rd;

  always #10 clk = ~clk;

  afull_sync_flag #(.DEPTH(DEPTH), .PRESET(PRESET)) dut_i (
    .wclk_i        (clk),
    .rst_ni        (rst_ni),
    .wr_ptr_i      (wr_ptr),
    .rd_ptr_gray_i (rd_gray),
    .off_load_i    (off_load),
    .off_data_i    (off_data),
    .afull_n_o     (afull_n)
  );

  function automatic logic [CNT_W-1:0] to_gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic bit exp_n(input int cnt, input int y);
    return !(cnt >= DEPTH - y);
  endfunction

  task automatic check(input bit got, input bit exp, input string req);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: afull_n_o=%0b expected %0b", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_off(input int y);
    off_load = 1'b1;
    off_data = OFF_W'(y);
    tick();
    off_load = 1'b0;
  endtask

  task automatic ramp_up(input int y, input int upto);
    for (int c = 1; c <= upto; c++) begin
      wr = wr + 1'b1;
      wr_ptr = wr;
      #1;
      if (c == DEPTH - y) check(afull_n, exp_n(c, y), "R4 same-cycle assert");
      else if (exp_n(c, y)) check(afull_n, 1'b1, "R3 below threshold");
      else check(afull_n, 1'b0, "R2 at/above threshold");
      tick();
    end
  endtask

  task automatic ramp_down(input int y, input int from);
    for (int c = from - 1; c >= 0; c--) begin
      rd = rd + 1'b1;
      rd_gray = to_gray(rd);
      tick();
      check(afull_n, exp_n(c + 1, y), "R5 first edge holds old value");
      tick();
      if (rd == '0) check(afull_n, exp_n(c, y), "R7 read pointer wrap");
      else check(afull_n, exp_n(c, y), "R5 second edge updates / R3");
    end
  endtask

  initial begin
    rst_ni   = 1'b0;
    wr = '0; rd = '0;
    wr_ptr   = '0;
    rd_gray  = '0;
    off_load = 1'b0;
    off_data = '0;
    repeat (3) @(negedge clk);
    check(afull_n, 1'b1, "R1 flag high in reset");
    rst_ni = 1'b1;
    tick();
    check(afull_n, 1'b1, "R1 flag high after reset");

    // preset threshold then full sweep of every offset
    ramp_up(PRESET, DEPTH);
    ramp_down(PRESET, DEPTH);
    for (int y = 0; y < DEPTH; y++) begin
      load_off(y);
      check(afull_n, 1'b1, "R6 empty after load");
      ramp_up(y, DEPTH);
      ramp_down(y, DEPTH);
    end

    // offset reload with a fixed fill of 8
    load_off(2);
    ramp_up(2, 8);
    off_load = 1'b1;
    off_data = OFF_W'(10);
    #1;
    check(afull_n, 1'b1, "R6 no change before edge");
    tick();
    off_load = 1'b0;
    check(afull_n, 1'b0, "R6 lower threshold applied");
    off_data = OFF_W'(1);
    tick();
    check(afull_n, 1'b0, "R6 held without load");
    load_off(7);
    check(afull_n, 1'b1, "R6 higher threshold applied");

    // reset mid-run restores the preset
    rst_ni = 1'b0;
    wr = '0; rd = '0;
    wr_ptr  = '0;
    rd_gray = '0;
    #1;
    check(afull_n, 1'b1, "R1 flag high in reset mid-run");
    tick();
    rst_ni = 1'b1;
    tick();
    ramp_up(PRESET, DEPTH - PRESET - 1);
    check(afull_n, 1'b1, "R1 preset restored below threshold");
    wr = wr + 1'b1;
    wr_ptr = wr;
    #1;
    check(afull_n, 1'b0, "R1 preset restored at threshold");
    tick();

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule